// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Bit-Slip Alignment

This block turns a serial NRZ bit stream, sampled once per bit clock, into parallel words of four bits. One of two serial inputs is picked by a select line and fed into a shift register. A free-running phase counter marks word boundaries. It also provides two slower clocks: the bit clock divided by the word width (four) and by twice that (eight). The parallel output is loaded at the counter's terminal count and holds its value in between.

A wide-mode input stretches the update interval to eight bit clocks, so two converters can share one stream. The first converter passes its delayed serial data to the second one, and together they present an eight-bit word.

Word alignment is corrected with a slip input. The slip input may be asynchronous. It is synchronized, and each rising edge makes the phase counter skip one count. This moves the word boundary by one bit. A synchronous reset clears the counter, the synchronizer and all data registers, so several converters can be started in step.

Top module: `bitslip_deser`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `parOut` is 0, `serOut` is 0 and both divided clocks are low.
- R2: Within a loaded word, the earliest sampled bit sits on `parOut[0]` and the latest on `parOut[3]`.
- R3: With `modeWide` low and no slip, `parOut` changes only on every fourth clock edge after reset (edges 4, 8, 12, ...), and it then holds the last four sampled bits.
- R4: With `modeWide` high, loads happen only when the phase counter is at 7, so once every eight clock edges. A load takes the last four sampled bits.
- R5: `clkDivWord` is bit 1 and `clkDivPair` is bit 2 of a phase count that starts at 0 after reset and advances by one on each clock edge. Without slips they are square waves with periods 4 and 8. `clkDivPair` changes only when `clkDivWord` falls.
- R6: `selB` = 0 samples `sinA` and `selB` = 1 samples `sinB`. The input that is not selected has no effect on any output.
- R7: A rising edge of `syncIn` that is first sampled high at clock edge a makes the phase counter hold at edge a+2. No load happens at that edge. Word boundaries then fall one bit later, so a bit that used to appear on `parOut[n]` appears on `parOut[n-1]`.
- R8: `syncIn` held high for any number of cycles causes exactly one skipped count. Each further skip needs a new low-to-high transition, with `syncIn` held for at least two clocks.
- R9: `serOut` shows the oldest shift-register stage: the bit sampled three edges earlier than the most recent one. A second converter clocked alongside therefore receives the stream four bits late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| syncIn | input | 1 | Asynchronous slip request; each rising edge skips one count |
| modeWide | input | 1 | 0: load every 4 clocks; 1: load every 8 clocks |
| selB | input | 1 | Serial source select, 0 = sinA, 1 = sinB |
| sinA | input | 1 | Serial data source A |
| sinB | input | 1 | Serial data source B |
| parOut | output | WORD_W | Parallel word, earliest bit in bit 0 |
| serOut | output | 1 | Delayed serial data for a cascaded converter |
| clkDivWord | output | 1 | Bit clock divided by WORD_W |
| clkDivPair | output | 1 | Bit clock divided by 2*WORD_W |

## Verification
The bench builds the block with its defaults: a word width of 4 and a two-stage synchronizer. The phase counter is then only three bits, so random streams walk every phase of both modes many times over. Four successive slips turn the word boundary through every alignment and back to the start. A slip held for twenty cycles shows that a long request still moves the boundary by only one bit. The expected word, serial tap and divided clocks are recomputed from the sampled bits and the edge count of each slip.

// File: rtl/deser_pkg.sv
package deser_pkg;
  // Strobes sent from the phase control to the datapath
  typedef struct packed {
    logic load;  // capture the shift register into the parallel output
    logic hold;  // phase counter skips this edge (slip)
  } deserStrobes_t;
endpackage

// File: rtl/deser_ctrl.sv
module deser_ctrl
  import deser_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          syncIn,
  input  logic          modeWide,
  output deserStrobes_t strobes,
  output logic          clkDivWord,
  output logic          clkDivPair
);
  localparam int PHASE_W = $clog2(WORD_W);
  localparam int CNT_W   = PHASE_W + 1;

  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   syncLast;
  logic [CNT_W-1:0]       phaseCnt;
  logic                   slipHold;
  logic                   termCount;

  // Metastability chain for the asynchronous slip request
  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : gSync
      if (i == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) syncPipe[i] <= 1'b0;
          else     syncPipe[i] <= syncIn;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (rst) syncPipe[i] <= 1'b0;
          else     syncPipe[i] <= syncPipe[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) syncLast <= 1'b0;
    else     syncLast <= syncPipe[SYNC_STAGES-1];
  end

  // One hold cycle per rising edge of the synchronized request
  assign slipHold = syncPipe[SYNC_STAGES-1] & ~syncLast;

  always_ff @(posedge clk) begin
    if (rst)            phaseCnt <= '0;
    else if (!slipHold) phaseCnt <= phaseCnt + CNT_W'(1);
  end

  assign termCount = modeWide ? (&phaseCnt) : (&phaseCnt[PHASE_W-1:0]);

  always_comb begin
    strobes.load = termCount & ~slipHold;
    strobes.hold = slipHold;
  end

  assign clkDivWord = phaseCnt[PHASE_W-1];
  assign clkDivPair = phaseCnt[CNT_W-1];
endmodule

// File: rtl/deser_data.sv
module deser_data #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selB,
  input  logic              sinA,
  input  logic              sinB,
  input  logic              loadWord,
  output logic [WORD_W-1:0] parOut,
  output logic              serOut
);
  logic              serialBit;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] shiftNext;

  assign serialBit = selB ? sinB : sinA;

  // Newest bit enters at the top; the oldest ends in stage 0
  genvar i;
  generate
    for (i = 0; i < WORD_W; i++) begin : gStage
      if (i == WORD_W - 1) begin : gTop
        assign shiftNext[i] = serialBit;
      end else begin : gMid
        assign shiftNext[i] = shiftReg[i+1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else     shiftReg <= shiftNext;
  end

  always_ff @(posedge clk) begin
    if (rst)           parOut <= '0;
    else if (loadWord) parOut <= shiftNext;
  end

  assign serOut = shiftReg[0];
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
  import deser_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              syncIn,
  input  logic              modeWide,
  input  logic              selB,
  input  logic              sinA,
  input  logic              sinB,
  output logic [WORD_W-1:0] parOut,
  output logic              serOut,
  output logic              clkDivWord,
  output logic              clkDivPair
);
  deserStrobes_t strobes;

  deser_ctrl #(
    .WORD_W     (WORD_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .syncIn    (syncIn),
    .modeWide  (modeWide),
    .strobes   (strobes),
    .clkDivWord(clkDivWord),
    .clkDivPair(clkDivPair)
  );

  deser_data #(
    .WORD_W(WORD_W)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .selB    (selB),
    .sinA    (sinA),
    .sinB    (sinB),
    .loadWord(strobes.load),
    .parOut  (parOut),
    .serOut  (serOut)
  );
endmodule

// File: rtl/bitslip_deser_chk.sv
module bitslip_deser_chk
  import deser_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              modeWide,
  input deserStrobes_t     strobes,
  input logic [WORD_W-1:0] parOut,
  input logic              serOut,
  input logic              clkDivWord,
  input logic              clkDivPair
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (parOut == '0 && !serOut && !clkDivWord && !clkDivPair));

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(parOut));

  assert_load_phase_R3: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && !modeWide) |-> clkDivWord);

  assert_wide_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && modeWide) |-> (clkDivWord && clkDivPair));

  assert_pair_follows_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(clkDivPair) |-> $fell(clkDivWord));

  assert_swallow_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.hold |=> ($stable(clkDivWord) && $stable(clkDivPair)));

  assert_single_swallow_R8: assert property (@(posedge clk) disable iff (rst)
    strobes.hold |=> !strobes.hold);
endmodule

bind bitslip_deser bitslip_deser_chk #(.WORD_W(WORD_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .modeWide  (modeWide),
  .strobes   (strobes),
  .parOut    (parOut),
  .serOut    (serOut),
  .clkDivWord(clkDivWord),
  .clkDivPair(clkDivPair)
);

// File: tb/bitslip_deser_test.sv
`timescale 1ns/1ps
module bitslip_deser_test;
  localparam int WORD_W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, syncIn, modeWide, selB, sinA, sinB;
  logic [WORD_W-1:0] parOut;
  logic serOut, clkDivWord, clkDivPair;

  bitslip_deser #(.WORD_W(WORD_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .syncIn(syncIn), .modeWide(modeWide),
    .selB(selB), .sinA(sinA), .sinB(sinB), .parOut(parOut),
    .serOut(serOut), .clkDivWord(clkDivWord), .clkDivPair(clkDivPair)
  );

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [3:0] refShift, refPar;
  logic [2:0] refCnt;
  int edgeNo = 0;
  int swallowAt = -1;
  logic lastSync = 1'b0;
  string curTag = "R1";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at edge %0d", tag, act, exp, edgeNo);
    end
  endtask

  // Called at a falling edge: apply inputs, advance one rising edge, compare
  task automatic step(input logic a, input logic b, input logic s);
    logic bitv;
    logic holdNow;
    sinA = a; sinB = b; syncIn = s;
    @(posedge clk);
    edgeNo++;
    if (s && !lastSync) swallowAt = edgeNo + 2;  // R7 timing
    lastSync = s;
    bitv = selB ? b : a;
    holdNow = (edgeNo == swallowAt);
    refShift = {bitv, refShift[3:1]};
    if (!holdNow && (modeWide ? (refCnt == 3'd7) : (refCnt[1:0] == 2'd3)))
      refPar = refShift;
    if (!holdNow) refCnt = refCnt + 3'd1;
    @(negedge clk);
    check(curTag, parOut, refPar);
    check("R5", clkDivWord, refCnt[1]);
    check("R5", clkDivPair, refCnt[2]);
    check("R9", serOut, refShift[0]);
  endtask

  task automatic doReset();
    rst = 1'b1; syncIn = 1'b0; sinA = 1'b0; sinB = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", parOut, 0);
    check("R1", serOut, 0);
    check("R1", clkDivWord, 0);
    check("R1", clkDivPair, 0);
    rst = 1'b0;
    refShift = '0; refPar = '0; refCnt = '0; lastSync = 1'b0; swallowAt = -1;
  endtask

  task automatic randomRun(input int n, input logic s);
    for (int k = 0; k < n; k++) step($urandom_range(0, 1), $urandom_range(0, 1), s);
  endtask

  initial begin
    rst = 1'b1; modeWide = 1'b0; selB = 1'b0; syncIn = 1'b0; sinA = 1'b0; sinB = 1'b0;
    @(negedge clk);
    doReset();

    // R2: bit order inside a word
    curTag = "R2";
    step(1, 0, 0); step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
    check("R2", parOut, 4'b0001);
    step(0, 1, 0); step(0, 0, 0); step(1, 0, 0); step(1, 1, 0);
    check("R2", parOut, 4'b1100);

    // R3: narrow mode, random data
    curTag = "R3";
    randomRun(64, 0);

    // R6: source B selected; A held busy, then B quiet while A toggles
    curTag = "R6";
    selB = 1'b1;
    randomRun(64, 0);
    for (int k = 0; k < 8; k++) step(k[0], 0, 0);
    check("R6", parOut, 4'b0000);
    selB = 1'b0;
    for (int k = 0; k < 8; k++) step(1, k[0], 0);
    check("R6", parOut, 4'b1111);

    // R4: wide mode
    curTag = "R4";
    doReset();
    modeWide = 1'b1;
    randomRun(64, 0);

    // R7: four single slips walk the boundary around all alignments
    curTag = "R7";
    doReset();
    modeWide = 1'b0;
    for (int p = 0; p < 4; p++) begin
      randomRun(3, 1);
      randomRun(13, 0);
    end
    modeWide = 1'b1;
    randomRun(3, 1);
    randomRun(21, 0);

    // R8: one long request gives one slip only
    curTag = "R8";
    modeWide = 1'b0;
    randomRun(20, 1);
    randomRun(16, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule